// File: doc/BRIEF.md
# Progressive-Precision Page Read Sequencer

This block controls the retry flow of a single page read for a flash error-correction path. When a read is accepted, it first asks the sensing logic for a hard-decision sense. That sense uses one level fewer than the number of cell states. It then starts the hard-decision decoder. Each time a decode reports failure, the block moves one step up a parameterised precision ladder. At each step it requests a finer sense and runs the soft-decision decoder. This repeats until a decode succeeds or the top step has failed.

The block also chooses which parity-check code to use from the program/erase cycle count. The count is compared against a rising set of wear boundaries. The chosen code index and its column weight are captured when the read is accepted. They stay fixed for every retry of that read. The sensing circuitry and both decoders sit outside the block and are reached through simple request/done handshakes.

Top module: `prec_read_seq`

## Requirements
- R1: The first sense of every read requests 2**CELL_BITS-1 levels (3 by default) and marks the decode as hard (`dec_soft`=0).
- R2: `sense_req` stays high with stable `sense_levels` until `sense_done` is seen. In the next cycle `sense_req` is low and `dec_start` is high for exactly one cycle.
- R3: When a decode fails below the top step, the cycle after `dec_done` shows `sense_req` high again, with the next ladder count (default ladder 3, 6, 10, 15) and `dec_soft`=1.
- R4: When a decode succeeds, the cycle after `dec_done` shows a one-cycle `rd_done` with `rd_uncorr`=0 and `attempts` equal to the number of senses made in that read.
- R5: When the decode at the top step (attempt NUM_STEPS, 4 by default) fails, the read ends with `rd_done` and `rd_uncorr`=1, and `attempts` equals NUM_STEPS.
- R6: Code index k is chosen when BOUNDS[k-1] <= count < BOUNDS[k]. Below the first boundary the index is 0, and from the last boundary up there is no limit. The default boundaries are 1000 and 3000, and the weights for index 0, 1 and 2 are 3, 4 and 5.
- R7: `dec_code` and `dec_weight` are captured at acceptance and held for the whole read, even if `pe_count` changes.
- R8: `rd_req` has no effect while a read is in progress. After that read ends, no second read starts.
- R9: `busy` rises in the cycle after acceptance and falls in the same cycle in which `rd_done` rises.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, accepted only when idle |
| pe_count | input | CNT_W | Program/erase cycle count |
| sense_req | output | 1 | Sense request, held until sense_done |
| sense_levels | output | LVL_W | Quantization level count for the sense |
| sense_done | input | 1 | Sense finished |
| dec_start | output | 1 | One-cycle decoder start pulse |
| dec_soft | output | 1 | 0 = hard-decision decoder, 1 = soft-decision decoder |
| dec_code | output | CODE_W | Selected code index |
| dec_weight | output | WT_W | Column weight of the selected code |
| dec_done | input | 1 | Decoder finished |
| dec_fail | input | 1 | Decode failed, qualified by dec_done |
| busy | output | 1 | Read in progress |
| rd_done | output | 1 | One-cycle completion pulse |
| rd_uncorr | output | 1 | 1 = uncorrectable at completion |
| attempts | output | STEP_W | Number of sense/decode attempts in the read |

## Verification
Every output is a register, so each response appears one clock after the input that causes it. Acceptance shows `busy`, `sense_req` and the code one cycle after `rd_req`. `dec_start` follows one cycle after `sense_done`. Either `rd_done` or the next `sense_req` follows one cycle after `dec_done`. The bench drives inputs on the falling edge and reads outputs at the next falling edge, exactly one rising edge later. It also holds `sense_done` back for extra cycles to confirm that the request waits.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SENSE  = 2'd1,
    ST_DECODE = 2'd2
  } prr_state_e;
endpackage

// File: rtl/prr_code_sel.sv
module prr_code_sel #(
  parameter int NUM_CODES = 3,
  parameter int CNT_W     = 20,
  parameter int CODE_W    = 2,
  parameter int WT_W      = 4,
  parameter logic [(NUM_CODES-1)*CNT_W-1:0] BOUNDS  = {20'd3000, 20'd1000},
  parameter logic [NUM_CODES*WT_W-1:0]      WEIGHTS = {4'd5, 4'd4, 4'd3}
) (
  input  logic [CNT_W-1:0]  count,
  output logic [CODE_W-1:0] idx,
  output logic [WT_W-1:0]   weight
);
  // boundaries rise, so the last one passed gives the interval index
  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_CODES-1; k++) begin
      if (count >= BOUNDS[k*CNT_W +: CNT_W]) idx = CODE_W'(k+1);
    end
  end

  always_comb begin
    weight = WEIGHTS[0 +: WT_W];
    for (int k = 1; k < NUM_CODES; k++) begin
      if (idx == CODE_W'(k)) weight = WEIGHTS[k*WT_W +: WT_W];
    end
  end
endmodule

// File: rtl/prr_ladder.sv
module prr_ladder #(
  parameter int NUM_STEPS = 4,
  parameter int LVL_W     = 5,
  parameter int CELL_BITS = 2,
  parameter int STEP_W    = 3,
  parameter logic [(NUM_STEPS-1)*LVL_W-1:0] SOFT_LEVELS = {5'd15, 5'd10, 5'd6}
) (
  input  logic [STEP_W-1:0] step,
  output logic [LVL_W-1:0]  levels
);
  localparam logic [LVL_W-1:0] HARD_LVL = LVL_W'((1 << CELL_BITS) - 1);

  logic [LVL_W-1:0] tbl [NUM_STEPS];

  assign tbl[0] = HARD_LVL;
  for (genvar g = 1; g < NUM_STEPS; g++) begin : g_soft
    assign tbl[g] = SOFT_LEVELS[(g-1)*LVL_W +: LVL_W];
  end

  always_comb begin
    levels = tbl[NUM_STEPS-1];
    for (int g = 0; g < NUM_STEPS; g++) begin
      if (step == STEP_W'(g)) levels = tbl[g];
    end
  end
endmodule

// File: rtl/prr_ctrl.sv
module prr_ctrl
  import prr_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  parameter int LVL_W     = 5,
  parameter int CELL_BITS = 2,
  parameter int STEP_W    = 3,
  parameter int CODE_W    = 2,
  parameter int WT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [CODE_W-1:0] sel_idx,
  input  logic [WT_W-1:0]   sel_wt,
  input  logic [LVL_W-1:0]  lad_levels,
  output logic [STEP_W-1:0] lad_step,
  output logic              sense_req,
  output logic [LVL_W-1:0]  sense_levels,
  input  logic              sense_done,
  output logic              dec_start,
  output logic              dec_soft,
  output logic [CODE_W-1:0] dec_code,
  output logic [WT_W-1:0]   dec_weight,
  input  logic              dec_done,
  input  logic              dec_fail,
  output logic              busy,
  output logic              rd_done,
  output logic              rd_uncorr,
  output logic [STEP_W-1:0] attempts
);
  localparam logic [LVL_W-1:0]  HARD_LVL = LVL_W'((1 << CELL_BITS) - 1);
  localparam logic [STEP_W-1:0] TOP_ATT  = STEP_W'(NUM_STEPS);

  prr_state_e state;

  // next ladder step: 0 when starting, else the count of attempts so far
  assign lad_step = (state == ST_IDLE) ? '0 : attempts;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      sense_req    <= 1'b0;
      sense_levels <= '0;
      dec_start    <= 1'b0;
      dec_soft     <= 1'b0;
      dec_code     <= '0;
      dec_weight   <= '0;
      busy         <= 1'b0;
      rd_done      <= 1'b0;
      rd_uncorr    <= 1'b0;
      attempts     <= '0;
    end else begin
      rd_done   <= 1'b0;
      dec_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rd_req) begin
            state        <= ST_SENSE;
            busy         <= 1'b1;
            attempts     <= STEP_W'(1);
            sense_req    <= 1'b1;
            sense_levels <= lad_levels;
            dec_soft     <= 1'b0;
            dec_code     <= sel_idx;
            dec_weight   <= sel_wt;
            rd_uncorr    <= 1'b0;
          end
        end
        ST_SENSE: begin
          if (sense_done) begin
            sense_req <= 1'b0;
            dec_start <= 1'b1;
            state     <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (dec_done) begin
            if (!dec_fail) begin
              state   <= ST_IDLE;
              busy    <= 1'b0;
              rd_done <= 1'b1;
            end else if (attempts == TOP_ATT) begin
              state     <= ST_IDLE;
              busy      <= 1'b0;
              rd_done   <= 1'b1;
              rd_uncorr <= 1'b1;
            end else begin
              state        <= ST_SENSE;
              attempts     <= attempts + STEP_W'(1);
              sense_req    <= 1'b1;
              sense_levels <= lad_levels;
              dec_soft     <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FIRST_HARD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (sense_levels == HARD_LVL && !dec_soft)); // R1
  AST_SENSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sense_req && !sense_done) |=> (sense_req && $stable(sense_levels))); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_start |=> !dec_start); // R2
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dec_start |-> $past(sense_req && sense_done)); // R2
  AST_RETRY_SOFT: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(sense_req) && !$rose(busy)) |-> dec_soft); // R3
  AST_ATT_BOUND: assert property (@(posedge clk) disable iff (rst)
    attempts <= TOP_ATT); // R5
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(dec_code) && $stable(dec_weight))); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (!busy && !sense_req)); // R9
endmodule

// File: rtl/prec_read_seq.sv
module prec_read_seq #(
  parameter int NUM_CODES = 3,
  parameter int CNT_W     = 20,
  parameter int WT_W      = 4,
  parameter int NUM_STEPS = 4,
  parameter int LVL_W     = 5,
  parameter int CELL_BITS = 2,
  parameter logic [(NUM_CODES-1)*CNT_W-1:0] BOUNDS      = {20'd3000, 20'd1000},
  parameter logic [NUM_CODES*WT_W-1:0]      WEIGHTS     = {4'd5, 4'd4, 4'd3},
  parameter logic [(NUM_STEPS-1)*LVL_W-1:0] SOFT_LEVELS = {5'd15, 5'd10, 5'd6},
  localparam int CODE_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1,
  localparam int STEP_W = $clog2(NUM_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [CNT_W-1:0]  pe_count,
  output logic              sense_req,
  output logic [LVL_W-1:0]  sense_levels,
  input  logic              sense_done,
  output logic              dec_start,
  output logic              dec_soft,
  output logic [CODE_W-1:0] dec_code,
  output logic [WT_W-1:0]   dec_weight,
  input  logic              dec_done,
  input  logic              dec_fail,
  output logic              busy,
  output logic              rd_done,
  output logic              rd_uncorr,
  output logic [STEP_W-1:0] attempts
);
  logic [CODE_W-1:0] sel_idx;
  logic [WT_W-1:0]   sel_wt;
  logic [STEP_W-1:0] lad_step;
  logic [LVL_W-1:0]  lad_levels;

  prr_code_sel #(
    .NUM_CODES(NUM_CODES), .CNT_W(CNT_W), .CODE_W(CODE_W), .WT_W(WT_W),
    .BOUNDS(BOUNDS), .WEIGHTS(WEIGHTS)
  ) u_code_sel (
    .count(pe_count), .idx(sel_idx), .weight(sel_wt)
  );

  prr_ladder #(
    .NUM_STEPS(NUM_STEPS), .LVL_W(LVL_W), .CELL_BITS(CELL_BITS),
    .STEP_W(STEP_W), .SOFT_LEVELS(SOFT_LEVELS)
  ) u_ladder (
    .step(lad_step), .levels(lad_levels)
  );

  prr_ctrl #(
    .NUM_STEPS(NUM_STEPS), .LVL_W(LVL_W), .CELL_BITS(CELL_BITS),
    .STEP_W(STEP_W), .CODE_W(CODE_W), .WT_W(WT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .sel_idx(sel_idx), .sel_wt(sel_wt),
    .lad_levels(lad_levels), .lad_step(lad_step),
    .sense_req(sense_req), .sense_levels(sense_levels), .sense_done(sense_done),
    .dec_start(dec_start), .dec_soft(dec_soft),
    .dec_code(dec_code), .dec_weight(dec_weight),
    .dec_done(dec_done), .dec_fail(dec_fail),
    .busy(busy), .rd_done(rd_done), .rd_uncorr(rd_uncorr), .attempts(attempts)
  );
endmodule

// File: tb/prec_read_seq_bench.sv
module prec_read_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [19:0] pe_count = '0;
  logic        sense_done = 1'b0;
  logic        dec_done = 1'b0;
  logic        dec_fail = 1'b0;
  logic        sense_req, dec_start, dec_soft, busy, rd_done, rd_uncorr;
  logic [4:0]  sense_levels;
  logic [1:0]  dec_code;
  logic [3:0]  dec_weight;
  logic [2:0]  attempts;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prec_read_seq u_prec_read_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .pe_count(pe_count),
    .sense_req(sense_req), .sense_levels(sense_levels), .sense_done(sense_done),
    .dec_start(dec_start), .dec_soft(dec_soft), .dec_code(dec_code),
    .dec_weight(dec_weight), .dec_done(dec_done), .dec_fail(dec_fail),
    .busy(busy), .rd_done(rd_done), .rd_uncorr(rd_uncorr), .attempts(attempts)
  );

  typedef struct packed {
    logic [19:0] pe;
    logic [3:0]  fmask;   // bit a set: attempt a fails
    logic [1:0]  code;
    logic [3:0]  wt;
    logic [2:0]  att;
    logic        unc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{20'd0,       4'b0000, 2'd0, 4'd3, 3'd1, 1'b0},
    '{20'd999,     4'b0001, 2'd0, 4'd3, 3'd2, 1'b0},
    '{20'd1000,    4'b0011, 2'd1, 4'd4, 3'd3, 1'b0},
    '{20'd2999,    4'b0111, 2'd1, 4'd4, 3'd4, 1'b0},
    '{20'd3000,    4'b1111, 2'd2, 4'd5, 3'd4, 1'b1},
    '{20'hFFFFF,   4'b0000, 2'd2, 4'd5, 3'd1, 1'b0},
    '{20'd1500,    4'b1111, 2'd1, 4'd4, 3'd4, 1'b1}
  };
  localparam int LAD [4] = '{3, 6, 10, 15};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_read(input vec_t v, input bit stall, input bit poke, input bit swap_pe);
    @(negedge clk);
    pe_count = v.pe;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R9 busy after accept", busy, 1);
    chk("R6 code index", dec_code, v.code);
    chk("R6 column weight", dec_weight, v.wt);
    for (int a = 0; a < 4; a++) begin
      chk("R1/R3 sense_req", sense_req, 1);
      chk("R1/R3 sense levels", sense_levels, LAD[a]);
      chk("R1/R3 decoder kind", dec_soft, (a != 0) ? 1 : 0);
      if (stall && a == 0) begin
        if (poke) begin
          rd_req = 1'b1;
          pe_count = 20'd5;
        end
        repeat (3) @(negedge clk);
        rd_req = 1'b0;
        chk("R2 sense_req held", sense_req, 1);
        chk("R2 no early start", dec_start, 0);
        chk("R2 levels stable", sense_levels, LAD[0]);
      end
      sense_done = 1'b1;
      @(negedge clk);
      sense_done = 1'b0;
      chk("R2 dec_start pulse", dec_start, 1);
      chk("R2 sense_req dropped", sense_req, 0);
      @(negedge clk);
      chk("R2 dec_start one cycle", dec_start, 0);
      if (swap_pe) pe_count = 20'd0;
      dec_done = 1'b1;
      dec_fail = v.fmask[a];
      @(negedge clk);
      dec_done = 1'b0;
      dec_fail = 1'b0;
      if (!v.fmask[a] || a == 3) begin
        chk("R4/R5 rd_done", rd_done, 1);
        chk("R9 busy low at done", busy, 0);
        chk("R4/R5 uncorrectable flag", rd_uncorr, v.unc);
        chk("R4/R5 attempts", attempts, v.att);
        chk("R7 code held", dec_code, v.code);
        chk("R7 weight held", dec_weight, v.wt);
        break;
      end
      chk("R9 busy during retry", busy, 1);
    end
    @(negedge clk);
    chk("R4 rd_done one cycle", rd_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs while and just after reset
    rst = 1'b0;
    @(negedge clk);
    chk("R10 sense_req", sense_req, 0);
    chk("R10 sense_levels", sense_levels, 0);
    chk("R10 dec_start", dec_start, 0);
    chk("R10 dec_soft", dec_soft, 0);
    chk("R10 busy", busy, 0);
    chk("R10 rd_done", rd_done, 0);
    chk("R10 rd_uncorr", rd_uncorr, 0);
    chk("R10 attempts", attempts, 0);
    chk("R10 code", dec_code, 0);

    for (int i = 0; i < NV; i++) do_read(VECS[i], 1'b0, 1'b0, 1'b0);

    // R2, R8: held sense with a request poked while busy
    do_read(VECS[2], 1'b1, 1'b1, 1'b0);
    repeat (3) begin
      @(negedge clk);
      chk("R8 no second read busy", busy, 0);
      chk("R8 no second sense", sense_req, 0);
      chk("R8 attempts unchanged", attempts, 3);
    end

    // R7: wear count drops mid-read, code must stay
    do_read(VECS[4], 1'b0, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule